// File: doc/BRIEF.md
# DRAM Parity Check Controller

This block sits between a bus master port and a DRAM data path. On a write it computes one parity bit per byte lane of the 32-bit word and sends it to the DRAM beside the data. On a read it recomputes parity over the returned data and compares it, for the lanes the byte strobes enable, against the stored parity bits. Each access ends with one acknowledge pulse. That pulse is either a normal acknowledge or an error acknowledge, as the parity policy of the requesting master selects.

Two requester classes share the port: the main processor and an alternate master. A 2-bit mode word gives each class a policy of its own: no checking, interrupt reporting (full speed, error raised as a level interrupt), or checked (one extra clock on every access, error returned through the error acknowledge). A diagnostic control stores inverted parity on writes. A small processor status register keeps sticky flags for parity, local bus error and timeout faults, and a write-only clear bit resets them.

Top module: `dram_parity_ctl`

## Requirements
- R1: Mode bits `cfg_mode` = {enable, interrupt} select the policy. 00: none for both classes. 01: processor interrupt, alternate none. 10: both checked. 11: processor interrupt, alternate checked. `cyc_alt`=1 marks the alternate master.
- R2: On a write, `dram_wpar[i]` is the XOR of bits of byte lane i of the data (lane i = bits 8i+7..8i). When `cfg_wrong_par`=1 every bit is inverted. `dram_wr` pulses once per write with the data of that cycle.
- R3: With policy none or interrupt, the single acknowledge pulse appears exactly LAT clocks after the cycle in which `cyc_start` was accepted (LAT=3 by default). During a read acknowledge, `cyc_rdata` carries the DRAM word.
- R4: With the checked policy, every access, whether it has an error or not, acknowledges LAT+1 clocks after the start.
- R5: A checked read with a parity error on an enabled lane ends with `cyc_err_ack` instead of `cyc_ack`. The two are never high together.
- R6: An interrupt-policy read with a parity error ends with the normal `cyc_ack`. `irq_parity` rises the clock after the acknowledge and stays high until a status write with bit 4 = 1.
- R7: Under policy none, a parity error gives no error acknowledge, no interrupt and no status flag.
- R8: Only lanes whose `cyc_be` bit is 1 are checked. A mismatch on a disabled lane is not an error.
- R9: A write never produces an error. It always ends with `cyc_ack`, at the latency that its policy sets.
- R10: The status flags are sticky. Bit 0 is timeout, set by `flt_tmo`. Bit 1 is parity, set by a detected processor read error. Bit 2 is local bus error, set by `flt_lberr`. An alternate master error never sets bit 1.
- R11: A status write with bit 3 = 1 zeroes the three flags in that clock. An event in the same clock still sets its flag. Bits 3 and 4 always read as 0.
- R12: After reset no acknowledge is pending, `irq_parity` is low and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Parity policy select {enable, interrupt} |
| cfg_wrong_par | input | 1 | Store inverted parity on writes |
| cyc_start | input | 1 | Start an access (accepted when idle) |
| cyc_we | input | 1 | 1 = write, 0 = read |
| cyc_alt | input | 1 | 1 = alternate master, 0 = processor |
| cyc_be | input | 4 | Byte lane enables |
| cyc_wdata | input | 32 | Write data |
| cyc_rdata | output | 32 | Read data, valid with the acknowledge |
| cyc_ack | output | 1 | Normal acknowledge pulse |
| cyc_err_ack | output | 1 | Error acknowledge pulse |
| dram_wr | output | 1 | DRAM write strobe |
| dram_wdata | output | 32 | Data to DRAM |
| dram_wpar | output | 4 | Parity to DRAM |
| dram_rdata | input | 32 | Data from DRAM |
| dram_rpar | input | 4 | Parity from DRAM |
| flt_lberr | input | 1 | Local bus error event pulse |
| flt_tmo | input | 1 | Timeout event pulse |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 5 | Status write data (bit 3 clear flags, bit 4 clear interrupt) |
| stat_rdata | output | 5 | Status read value |
| irq_parity | output | 1 | Parity interrupt request, level |

## Verification
The hardest case to reach is a stored word whose parity disagrees with its data only on lanes that the byte strobes mask off, while the policy of the requesting class is exactly the one under test. The bench holds a one-word DRAM model. It can write that word with inverted parity or flip chosen parity lanes on the read path. Directed cases pair single-lane corruption with strobes that exclude that lane. Random traffic then mixes modes, master classes, strobes and corruption masks, and a bench model predicts latency, acknowledge type, interrupt and status for each access.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        POL_NONE  = 2'd0,
        POL_IRQ   = 2'd1,
        POL_CHECK = 2'd2
    } policy_e;

    typedef struct packed {
        logic    we;
        logic    alt;
        policy_e pol;
    } cyc_attr_t;

    // mode[1] = enable, mode[0] = interrupt
    function automatic policy_e pick_policy(input logic [1:0] mode, input logic alt);
        policy_e p;
        if (alt)          p = mode[1] ? POL_CHECK : POL_NONE;
        else if (mode[0]) p = POL_IRQ;
        else if (mode[1]) p = POL_CHECK;
        else              p = POL_NONE;
        return p;
    endfunction

    function automatic logic byte_par(input logic [7:0] b);
        return ^b;
    endfunction

    localparam int STAT_W    = 5;
    localparam int ST_TMO    = 0;
    localparam int ST_PERR   = 1;
    localparam int ST_LBERR  = 2;
    localparam int ST_CLR    = 3;
    localparam int ST_IRQCLR = 4;

endpackage

// File: rtl/dpc_lane_parity.sv
module dpc_lane_parity
    import dpc_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / 8
) (
    input  logic [DW-1:0]    wdata,
    input  logic             flip,
    output logic [LANES-1:0] wpar,
    input  logic [DW-1:0]    rdata,
    input  logic [LANES-1:0] rpar,
    input  logic [LANES-1:0] be,
    output logic             any_err
);
    logic [LANES-1:0] lane_err;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wpar[i]     = byte_par(wdata[8*i +: 8]) ^ flip;
        assign lane_err[i] = be[i] & (byte_par(rdata[8*i +: 8]) ^ rpar[i]);
    end

    assign any_err = |lane_err;

endmodule

// File: rtl/dpc_cycle_ctl.sv
module dpc_cycle_ctl
    import dpc_pkg::*;
#(
    parameter int LAT = 3,
    localparam int CW = $clog2(LAT + 2)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       we,
    input  logic       alt,
    input  logic [1:0] mode,
    input  logic       par_err,
    output logic       accept,
    output logic       cap_en,
    output logic       cap_rd,
    output logic       dram_wr,
    output logic       cyc_ack,
    output logic       cyc_err_ack,
    output logic       irq_ev,
    output logic       perr_ev
);
    logic            busy;
    logic [CW-1:0]   cnt;
    cyc_attr_t       attr;
    logic [CW-1:0]   last;
    logic            done;
    logic            rd_err;

    assign accept = start && !busy;
    assign last   = (attr.pol == POL_CHECK) ? CW'(LAT + 1) : CW'(LAT);
    assign done   = busy && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            attr <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            cnt      <= CW'(1);
            attr.we  <= we;
            attr.alt <= alt;
            attr.pol <= pick_policy(mode, alt);
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign cap_en  = busy && (cnt == CW'(LAT - 1));
    assign cap_rd  = cap_en && !attr.we;
    assign dram_wr = cap_en && attr.we;

    assign rd_err      = done && !attr.we && par_err;
    assign cyc_err_ack = rd_err && (attr.pol == POL_CHECK);
    assign cyc_ack     = done && !cyc_err_ack;
    assign irq_ev      = rd_err && !attr.alt && (attr.pol == POL_IRQ);
    assign perr_ev     = rd_err && !attr.alt && (attr.pol != POL_NONE);

    a_r5_one_ack: assert property (@(posedge clk) disable iff (rst)
        !(cyc_ack && cyc_err_ack));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (cyc_ack || cyc_err_ack) |=> !(cyc_ack || cyc_err_ack));
    a_r9_write_clean: assert property (@(posedge clk) disable iff (rst)
        (busy && attr.we) |-> !cyc_err_ack);
    a_r7_none_silent: assert property (@(posedge clk) disable iff (rst)
        (busy && attr.pol == POL_NONE) |-> !(cyc_err_ack || irq_ev || perr_ev));
    a_r4_no_early_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && attr.pol == POL_CHECK && cnt == CW'(LAT)) |-> !(cyc_ack || cyc_err_ack));

endmodule

// File: rtl/dpc_status.sv
module dpc_status
    import dpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              perr_ev,
    input  logic              lberr_ev,
    input  logic              tmo_ev,
    input  logic              irq_ev,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] rdata,
    output logic              irq
);
    logic [2:0] flags;
    logic [2:0] set_v;
    logic       clr_flags;
    logic       clr_irq;

    assign clr_flags = wr && wdata[ST_CLR];
    assign clr_irq   = wr && wdata[ST_IRQCLR];

    always_comb begin
        set_v           = '0;
        set_v[ST_TMO]   = tmo_ev;
        set_v[ST_PERR]  = perr_ev;
        set_v[ST_LBERR] = lberr_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= (clr_flags ? 3'b000 : flags) | set_v;
            if (irq_ev)       irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;
        end
    end

    assign rdata = {2'b00, flags};

    a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_irq) |=> irq);
    a_r10_sticky_perr: assert property (@(posedge clk) disable iff (rst)
        (flags[ST_PERR] && !clr_flags) |=> flags[ST_PERR]);
    a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !perr_ev && !lberr_ev && !tmo_ev) |=> (rdata == '0));

endmodule

// File: rtl/dram_parity_ctl.sv
module dram_parity_ctl
    import dpc_pkg::*;
#(
    parameter int LAT = 3,
    parameter int DW  = 32,
    localparam int LANES = DW / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_wrong_par,
    input  logic              cyc_start,
    input  logic              cyc_we,
    input  logic              cyc_alt,
    input  logic [LANES-1:0]  cyc_be,
    input  logic [DW-1:0]     cyc_wdata,
    output logic [DW-1:0]     cyc_rdata,
    output logic              cyc_ack,
    output logic              cyc_err_ack,
    output logic              dram_wr,
    output logic [DW-1:0]     dram_wdata,
    output logic [LANES-1:0]  dram_wpar,
    input  logic [DW-1:0]     dram_rdata,
    input  logic [LANES-1:0]  dram_rpar,
    input  logic              flt_lberr,
    input  logic              flt_tmo,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_parity
);
    logic             accept, cap_en, cap_rd;
    logic             par_err, irq_ev, perr_ev;
    logic [DW-1:0]    wdata_q, rdata_q;
    logic [LANES-1:0] be_q, rpar_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
            rpar_q  <= '0;
        end else begin
            if (accept) begin
                wdata_q <= cyc_wdata;
                be_q    <= cyc_be;
            end
            if (cap_rd) begin
                rdata_q <= dram_rdata;
                rpar_q  <= dram_rpar;
            end
        end
    end

    dpc_cycle_ctl #(.LAT(LAT)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start       (cyc_start),
        .we          (cyc_we),
        .alt         (cyc_alt),
        .mode        (cfg_mode),
        .par_err     (par_err),
        .accept      (accept),
        .cap_en      (cap_en),
        .cap_rd      (cap_rd),
        .dram_wr     (dram_wr),
        .cyc_ack     (cyc_ack),
        .cyc_err_ack (cyc_err_ack),
        .irq_ev      (irq_ev),
        .perr_ev     (perr_ev)
    );

    dpc_lane_parity #(.DW(DW)) u_par (
        .wdata   (wdata_q),
        .flip    (cfg_wrong_par),
        .wpar    (dram_wpar),
        .rdata   (rdata_q),
        .rpar    (rpar_q),
        .be      (be_q),
        .any_err (par_err)
    );

    dpc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .perr_ev  (perr_ev),
        .lberr_ev (flt_lberr),
        .tmo_ev   (flt_tmo),
        .irq_ev   (irq_ev),
        .wr       (stat_wr),
        .wdata    (stat_wdata),
        .rdata    (stat_rdata),
        .irq      (irq_parity)
    );

    assign dram_wdata = wdata_q;
    assign cyc_rdata  = rdata_q;

    a_r2_write_strobe_once: assert property (@(posedge clk) disable iff (rst)
        dram_wr |=> !dram_wr);
    a_r12_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(cyc_ack || cyc_err_ack || irq_parity));

endmodule

// File: tb/dram_parity_ctl_tb_top.sv
module dram_parity_ctl_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_mode;
    logic        cfg_wrong_par;
    logic        cyc_start, cyc_we, cyc_alt;
    logic [3:0]  cyc_be;
    logic [31:0] cyc_wdata, cyc_rdata;
    logic        cyc_ack, cyc_err_ack, dram_wr;
    logic [31:0] dram_wdata, dram_rdata;
    logic [3:0]  dram_wpar, dram_rpar;
    logic        flt_lberr, flt_tmo, stat_wr;
    logic [4:0]  stat_wdata, stat_rdata;
    logic        irq_parity;

    logic [31:0] mem_d;
    logic [3:0]  mem_p;
    logic [3:0]  corrupt;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model
    logic [31:0] m_d;
    logic [3:0]  m_p;
    logic        m_irq;
    logic [2:0]  m_flags;

    always #10 clk = ~clk;

    dram_parity_ctl #(.LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_wrong_par(cfg_wrong_par),
        .cyc_start(cyc_start), .cyc_we(cyc_we), .cyc_alt(cyc_alt), .cyc_be(cyc_be),
        .cyc_wdata(cyc_wdata), .cyc_rdata(cyc_rdata), .cyc_ack(cyc_ack),
        .cyc_err_ack(cyc_err_ack), .dram_wr(dram_wr), .dram_wdata(dram_wdata),
        .dram_wpar(dram_wpar), .dram_rdata(dram_rdata), .dram_rpar(dram_rpar),
        .flt_lberr(flt_lberr), .flt_tmo(flt_tmo), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .irq_parity(irq_parity)
    );

    always @(posedge clk) if (dram_wr) begin
        mem_d <= dram_wdata;
        mem_p <= dram_wpar;
    end
    assign dram_rdata = mem_d;
    assign dram_rpar  = mem_p ^ corrupt;

    function automatic logic [3:0] calc_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    // 0 none, 1 interrupt, 2 checked (R1)
    function automatic int calc_pol(input logic [1:0] mode, input logic alt);
        if (alt) return mode[1] ? 2 : 0;
        if (mode[0]) return 1;
        if (mode[1]) return 2;
        return 0;
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    task automatic access(input logic we, input logic alt, input logic [3:0] be,
                          input logic [31:0] d, input logic [3:0] cor);
        int pol, lat, exp_lat;
        logic err, exp_err_ack;
        logic [31:0] got_d;
        logic got_ack, got_err;
        pol = calc_pol(cfg_mode, alt);
        exp_lat = (pol == 2) ? LAT + 1 : LAT;
        err = !we && (pol != 0) && (|((m_p ^ cor ^ calc_par(m_d)) & be));
        exp_err_ack = err && (pol == 2);
        corrupt   = cor;
        cyc_start = 1'b1; cyc_we = we; cyc_alt = alt; cyc_be = be; cyc_wdata = d;
        @(negedge clk);
        cyc_start = 1'b0;
        lat = 1;
        while (!(cyc_ack || cyc_err_ack) && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        got_ack = cyc_ack; got_err = cyc_err_ack; got_d = cyc_rdata;
        if (pol == 2) chk(lat == exp_lat, "R4 checked latency", lat, exp_lat);
        else          chk(lat == exp_lat, "R3 unchecked latency", lat, exp_lat);
        if (we) begin
            chk(got_ack && !got_err, "R9 write acks normally", {got_err, got_ack}, 2'b01);
        end else begin
            chk(got_err == exp_err_ack && got_ack == !exp_err_ack,
                "R5 ack kind", {got_err, got_ack}, {exp_err_ack, !exp_err_ack});
            chk(got_d == m_d, "R3 read data", got_d, m_d);
        end
        if (err && pol == 1) m_irq = 1'b1;
        if (err && !alt) m_flags[1] = 1'b1;
        @(negedge clk);
        if (we) begin
            m_d = d;
            m_p = calc_par(d) ^ {4{cfg_wrong_par}};
            chk(mem_p == m_p && mem_d == m_d, "R2 stored parity", {mem_d, mem_p}, {m_d, m_p});
        end
        chk(irq_parity == m_irq, "R6 irq level", irq_parity, m_irq);
        chk(stat_rdata == {2'b00, m_flags}, "R10 status flags", stat_rdata, {2'b00, m_flags});
        corrupt = 4'h0;
    endtask

    task automatic stat_write(input logic [4:0] v);
        stat_wr = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = '0;
        if (v[3]) m_flags = '0;
        if (v[4]) m_irq = 1'b0;
        chk(stat_rdata == {2'b00, m_flags}, "R11 clear flags", stat_rdata, {2'b00, m_flags});
        chk(irq_parity == m_irq, "R6 irq clear", irq_parity, m_irq);
    endtask

    task automatic fault(input logic lb, input logic tm);
        flt_lberr = lb; flt_tmo = tm;
        @(negedge clk);
        flt_lberr = 1'b0; flt_tmo = 1'b0;
        if (lb) m_flags[2] = 1'b1;
        if (tm) m_flags[0] = 1'b1;
        chk(stat_rdata == {2'b00, m_flags}, "R10 fault flags", stat_rdata, {2'b00, m_flags});
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_mode = 2'b00; cfg_wrong_par = 1'b0;
        cyc_start = 0; cyc_we = 0; cyc_alt = 0; cyc_be = 0; cyc_wdata = 0;
        flt_lberr = 0; flt_tmo = 0; stat_wr = 0; stat_wdata = 0; corrupt = 0;
        m_irq = 0; m_flags = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!cyc_ack && !cyc_err_ack && !irq_parity && stat_rdata == 0,
            "R12 reset state", {cyc_ack, cyc_err_ack, irq_parity, stat_rdata}, 0);

        // seed memory with good parity
        access(1'b1, 1'b0, 4'hF, 32'hA5C3_0F11, 4'h0);
        // R7: no checking, corrupted read passes silently
        cfg_mode = 2'b00;
        access(1'b0, 1'b0, 4'hF, 0, 4'h5);
        // R1 / R6: processor interrupt mode, alternate unchecked
        cfg_mode = 2'b01;
        access(1'b0, 1'b1, 4'hF, 0, 4'h1);
        access(1'b0, 1'b0, 4'hF, 0, 4'h2);
        access(1'b0, 1'b0, 4'hF, 0, 4'h0);   // irq still held
        stat_write(5'b10000);
        // R8: corrupted lane masked off by strobes
        cfg_mode = 2'b10;
        access(1'b0, 1'b0, 4'hE, 0, 4'h1);
        access(1'b0, 1'b1, 4'h1, 0, 4'h1);
        // R2 wrong parity write, then R5 checked error
        cfg_wrong_par = 1'b1;
        access(1'b1, 1'b1, 4'hF, 32'h1234_5678, 4'h0);
        cfg_wrong_par = 1'b0;
        access(1'b0, 1'b0, 4'h8, 0, 4'h0);
        // R1 mode 11: alternate checked, processor interrupt
        cfg_mode = 2'b11;
        access(1'b0, 1'b1, 4'hF, 0, 4'h0);
        access(1'b0, 1'b0, 4'hF, 0, 4'h0);
        // R10 faults, R11 clear and readback of write-only bits
        fault(1'b1, 1'b0);
        fault(1'b0, 1'b1);
        stat_write(5'b11000);
        chk(stat_rdata[4:3] == 2'b00, "R11 write-only bits read 0", stat_rdata[4:3], 0);

        for (int k = 0; k < 400; k++) begin
            logic [3:0] cor;
            cfg_mode      = 2'($urandom_range(0, 3));
            cfg_wrong_par = ($urandom_range(0, 7) == 0);
            cor = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            access(1'($urandom), 1'($urandom), 4'($urandom), $urandom, cor);
            if ($urandom_range(0, 9) == 0) stat_write({1'($urandom), 1'($urandom), 3'b000});
            if ($urandom_range(0, 15) == 0) fault(1'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule